// File: doc/BRIEF.md
# Snooping Tag Emulator with Miss Stalls

This block sits on a pipelined, snooping system bus and pretends to be one more cache level. It keeps only tags, never data. Each read that reaches the bus is looked up in a direct-mapped tag store. A miss installs the line's tag and marks the transaction so that its snoop phase is stretched by a fixed number of stall windows. The requester therefore sees the stall time on top of the ordinary memory latency. A hit adds no stall, so the read finishes at plain memory latency. The effect is the latency profile of a larger cache hierarchy, with no data array behind it.

The bus monitor presents each new transaction once, with an operation code, a byte address and a transaction id that names one of several tracking slots. Later the bus presents each snoop window with the same id. The block answers every window on the next cycle. A stall is shown by driving the hit and hit-modified outputs high together; a window with both low lets the transaction leave the snoop phase. Two saturating counters record read hits and read misses for a host to read.

Top module: `snoop_tag_emu`

## Requirements
- R1: After reset no response is pending, both statistics counters read zero, and every tag entry is invalid, so the first read to any line misses.
- R2: A read (op code 0) that misses installs the line's tag, so a later read to any byte of the same line hits.
- R3: For a read that missed, the first STALLS snoop windows of its id are each answered with hit and hit-modified both high, and the next window is answered with both low, which releases the slot.
- R4: For a read that hit, the first snoop window of its id is answered with hit and hit-modified both low.
- R5: The tag store is direct-mapped. The set index is the address bits just above the line offset, and the tag is the bits above the index. Two lines with the same index and different tags evict each other, and lines with different indexes stay resident together.
- R6: A write (op code 1) or invalidate (op code 2) to a resident line clears its entry, so the next read to it misses. Writes and invalidates never install a tag, never change a counter, and get a clean snoop answer.
- R7: Up to SLOTS transactions are tracked at once, one per id. Snoop windows of different ids may interleave in any order, and each id keeps its own stall count.
- R8: The hit counter counts reads that hit and the miss counter counts reads that missed. Each counter changes by at most one per request and holds at its all-ones value.
- R9: A snoop window for an id with no tracked transaction gets a clean answer.
- R10: Each snoop window is answered exactly one cycle later by a response pulse that carries the window's id.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A new transaction enters the bus this cycle |
| req_op | input | 2 | Operation: 0 read, 1 write, 2 invalidate, 3 other |
| req_addr | input | ADDR_W | Byte address of the transaction |
| req_id | input | ID_W | Tracking slot of the new transaction |
| snp_valid | input | 1 | A snoop window is open this cycle |
| snp_id | input | ID_W | Transaction id of the snoop window |
| snp_rsp_valid | output | 1 | Answer to the snoop window of the previous cycle |
| snp_rsp_id | output | ID_W | Id of the answered window |
| snp_hit | output | 1 | Hit line of the snoop answer |
| snp_hitm | output | 1 | Hit-modified line of the snoop answer |
| hit_count | output | CNT_W | Saturating count of read hits |
| miss_count | output | CNT_W | Saturating count of read misses |

## Verification
The bench builds the block with a 16-bit address, 32-byte lines and a 256-byte capacity. That gives eight sets, so a conflict eviction or a co-resident line takes only a few crafted addresses. STALLS is 3, which lets the test walk the full stall countdown of several interleaved ids. CNT_W is 4, so the hit counter reaches its ceiling after a short run of repeated hits and the test can check that it holds there.

// File: rtl/snoop_tag_pkg.sv
package snoop_tag_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_INVAL = 2'd2,
        OP_OTHER = 2'd3
    } bus_op_e;

    function automatic int unsigned clog2_min1(input int unsigned v);
        int unsigned r;
        r = 0;
        while ((32'd1 << r) < v) r++;
        return (r == 0) ? 1 : r;
    endfunction

endpackage

// File: rtl/snoop_tag_store.sv
module snoop_tag_store #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 9,
    parameter int IDX_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    input  logic              alloc_en,
    input  logic              clear_en
);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
    localparam int SETS  = 1 << IDX_W;

    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;

    logic [SETS-1:0]  valid_d, valid_q;
    logic [TAG_W-1:0] tag_d [SETS];
    logic [TAG_W-1:0] tag_q [SETS];

    assign idx    = lk_addr[OFF_W +: IDX_W];
    assign tag    = lk_addr[OFF_W + IDX_W +: TAG_W];
    assign lk_hit = valid_q[idx] && (tag_q[idx] == tag);

    always_comb begin
        valid_d = valid_q;
        for (int s = 0; s < SETS; s++) tag_d[s] = tag_q[s];
        if (alloc_en) begin
            valid_d[idx] = 1'b1;
            tag_d[idx]   = tag;
        end else if (clear_en && lk_hit) begin
            valid_d[idx] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < SETS; s++) tag_q[s] <= tag_d[s];
    end

endmodule

// File: rtl/snoop_slot_table.sv
module snoop_slot_table #(
    parameter int SLOTS   = 8,
    parameter int ID_W    = 3,
    parameter int STALL_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_en,
    input  logic [ID_W-1:0]    start_id,
    input  logic [STALL_W-1:0] start_stalls,
    input  logic               snp_en,
    input  logic [ID_W-1:0]    snp_id,
    output logic               rsp_valid,
    output logic [ID_W-1:0]    rsp_id,
    output logic               rsp_stall,
    output logic [SLOTS-1:0]   busy
);
    typedef struct packed {
        logic               busy;
        logic [STALL_W-1:0] left;
    } slot_t;

    typedef struct packed {
        logic            valid;
        logic [ID_W-1:0] id;
        logic            stall;
    } rsp_t;

    slot_t slot_d [SLOTS];
    slot_t slot_q [SLOTS];
    rsp_t  rsp_d, rsp_q;

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_slot
            always_comb begin
                slot_d[g] = slot_q[g];
                if (start_en && start_id == ID_W'(g)) begin
                    slot_d[g].busy = 1'b1;
                    slot_d[g].left = start_stalls;
                end else if (snp_en && snp_id == ID_W'(g) && slot_q[g].busy) begin
                    if (slot_q[g].left != '0) slot_d[g].left = slot_q[g].left - 1'b1;
                    else                      slot_d[g].busy = 1'b0;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) slot_q[g] <= '0;
                else        slot_q[g] <= slot_d[g];
            end

            assign busy[g] = slot_q[g].busy;
        end
    endgenerate

    always_comb begin
        rsp_d.valid = snp_en;
        rsp_d.id    = snp_id;
        rsp_d.stall = snp_en && slot_q[snp_id].busy && (slot_q[snp_id].left != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_id    = rsp_q.id;
    assign rsp_stall = rsp_q.stall;

endmodule

// File: rtl/snoop_sat_counter.sv
module snoop_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && cnt_q != '1) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

endmodule

// File: rtl/snoop_tag_emu.sv
module snoop_tag_emu #(
    parameter int ADDR_W     = 32,
    parameter int CAP_BYTES  = 1048576,
    parameter int LINE_BYTES = 512,
    parameter int SLOTS      = 8,
    parameter int STALLS     = 3,
    parameter int CNT_W      = 16,
    parameter int ID_W       = snoop_tag_pkg::clog2_min1(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ID_W-1:0]   req_id,
    input  logic              snp_valid,
    input  logic [ID_W-1:0]   snp_id,
    output logic              snp_rsp_valid,
    output logic [ID_W-1:0]   snp_rsp_id,
    output logic              snp_hit,
    output logic              snp_hitm,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    import snoop_tag_pkg::*;

    localparam int OFF_W   = clog2_min1(LINE_BYTES);
    localparam int IDX_W   = clog2_min1(CAP_BYTES / LINE_BYTES);
    localparam int STALL_W = clog2_min1(STALLS + 1);

    bus_op_e            op;
    logic               is_read, is_clear, lk_hit;
    logic               rd_hit, rd_miss;
    logic [STALL_W-1:0] new_stalls;
    logic               rsp_stall;
    logic [SLOTS-1:0]   slot_busy;

    assign op       = bus_op_e'(req_op);
    assign is_read  = req_valid && (op == OP_READ);
    assign is_clear = req_valid && (op == OP_WRITE || op == OP_INVAL);
    assign rd_hit   = is_read && lk_hit;
    assign rd_miss  = is_read && !lk_hit;

    always_comb begin
        new_stalls = '0;
        if (rd_miss) new_stalls = STALL_W'(STALLS);
    end

    snoop_tag_store #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_addr  (req_addr),
        .lk_hit   (lk_hit),
        .alloc_en (rd_miss),
        .clear_en (is_clear)
    );

    snoop_slot_table #(.SLOTS(SLOTS), .ID_W(ID_W), .STALL_W(STALL_W)) u_slots (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_en     (req_valid),
        .start_id     (req_id),
        .start_stalls (new_stalls),
        .snp_en       (snp_valid),
        .snp_id       (snp_id),
        .rsp_valid    (snp_rsp_valid),
        .rsp_id       (snp_rsp_id),
        .rsp_stall    (rsp_stall),
        .busy         (slot_busy)
    );

    snoop_sat_counter #(.CNT_W(CNT_W)) u_hits (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (rd_hit),
        .count (hit_count)
    );

    snoop_sat_counter #(.CNT_W(CNT_W)) u_misses (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (rd_miss),
        .count (miss_count)
    );

    assign snp_hit  = rsp_stall;
    assign snp_hitm = rsp_stall;

endmodule

// File: rtl/snoop_tag_emu_checker.sv
module snoop_tag_emu_checker #(
    parameter int SLOTS = 8,
    parameter int ID_W  = 3,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             snp_valid,
    input logic [ID_W-1:0]  snp_id,
    input logic             snp_rsp_valid,
    input logic [ID_W-1:0]  snp_rsp_id,
    input logic             snp_hit,
    input logic             snp_hitm,
    input logic [CNT_W-1:0] hit_count,
    input logic [CNT_W-1:0] miss_count,
    input logic [SLOTS-1:0] slot_busy
);
    a_r10_rsp_after_window: assert property (@(posedge clk) disable iff (!rst_n)
        snp_rsp_valid |-> $past(snp_valid));

    a_r10_rsp_id_echo: assert property (@(posedge clk) disable iff (!rst_n)
        snp_rsp_valid |-> (snp_rsp_id == $past(snp_id)));

    a_r3_stall_inside_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_hit || snp_hitm) |-> snp_rsp_valid);

    a_r9_idle_slot_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && !slot_busy[snp_id]) |=> !snp_hit && !snp_hitm);

    a_r8_one_counter_moves: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_count != $past(hit_count) && miss_count != $past(miss_count)));

    a_r8_quiet_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> ($stable(hit_count) && $stable(miss_count)));

endmodule

bind snoop_tag_emu snoop_tag_emu_checker #(.SLOTS(SLOTS), .ID_W(ID_W), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .snp_valid     (snp_valid),
    .snp_id        (snp_id),
    .snp_rsp_valid (snp_rsp_valid),
    .snp_rsp_id    (snp_rsp_id),
    .snp_hit       (snp_hit),
    .snp_hitm      (snp_hitm),
    .hit_count     (hit_count),
    .miss_count    (miss_count),
    .slot_busy     (slot_busy)
);

// File: tb/snoop_tag_emu_test.sv
module snoop_tag_emu_test;
    localparam int AW = 16;
    localparam int IW = 3;
    localparam int CW = 4;
    localparam int NST = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [IW-1:0] req_id = '0;
    logic          snp_valid = 1'b0;
    logic [IW-1:0] snp_id = '0;
    logic          snp_rsp_valid, snp_hit, snp_hitm;
    logic [IW-1:0] snp_rsp_id;
    logic [CW-1:0] hit_count, miss_count;

    int checks = 0;
    int errors = 0;
    logic [IW:0] exp_q [$];

    always #2.5 clk = ~clk;

    snoop_tag_emu #(.ADDR_W(AW), .CAP_BYTES(256), .LINE_BYTES(32), .SLOTS(8),
                    .STALLS(NST), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_id(req_id), .snp_valid(snp_valid), .snp_id(snp_id),
        .snp_rsp_valid(snp_rsp_valid), .snp_rsp_id(snp_rsp_id), .snp_hit(snp_hit),
        .snp_hitm(snp_hitm), .hit_count(hit_count), .miss_count(miss_count));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected snoop answers (R3 R4 R9 R10)
    always @(negedge clk) begin
        if (rst_n && snp_rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected response", 32'(snp_rsp_id), 32'hFFFF);
            end else begin
                logic [IW:0] e;
                e = exp_q.pop_front();
                check("R10 response id", 32'(snp_rsp_id), 32'(e[IW:1]));
                check("R3/R4 stall answer", 32'({snp_hit, snp_hitm}), e[0] ? 32'd3 : 32'd0);
            end
        end
    end

    task automatic do_req(input logic [1:0] op, input logic [AW-1:0] a, input logic [IW-1:0] id);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_id = id;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic snoop_one(input logic [IW-1:0] id, input logic stall);
        @(negedge clk);
        snp_valid = 1'b1; snp_id = id;
        exp_q.push_back({id, stall});
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic snoop_run(input logic [IW-1:0] id, input int n);
        for (int k = 0; k < n; k++) snoop_one(id, 1'b1);
        snoop_one(id, 1'b0);
    endtask

    task automatic counters(input string req, input int h, input int m);
        check({req, " hit_count"}, 32'(hit_count), 32'(h));
        check({req, " miss_count"}, 32'(miss_count), 32'(m));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        check("watchdog expired", 32'd1, 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rsp_valid", 32'(snp_rsp_valid), 32'd0);
        counters("R1", 0, 0);

        // R1/R2/R3: first read misses, then stall countdown
        do_req(2'd0, 16'h0100, 3'd0);
        counters("R1 first read misses", 0, 1);
        snoop_run(3'd0, NST);
        // R2/R4: same line other offset hits, clean snoop
        do_req(2'd0, 16'h0110, 3'd1);
        counters("R2 same line hits", 1, 1);
        snoop_run(3'd1, 0);

        // R5: conflict eviction at index 0, coexistence at index 1
        do_req(2'd0, 16'h0200, 3'd2);
        do_req(2'd0, 16'h0100, 3'd3);
        counters("R5 conflict evicts", 1, 3);
        do_req(2'd0, 16'h0120, 3'd4);
        do_req(2'd0, 16'h0100, 3'd5);
        counters("R5 other index coexists", 2, 4);

        // R7: interleaved snoop windows across ids
        snoop_one(3'd5, 1'b0);
        for (int k = 0; k < NST; k++) begin
            snoop_one(3'd2, 1'b1);
            snoop_one(3'd4, 1'b1);
            snoop_one(3'd3, 1'b1);
        end
        snoop_one(3'd2, 1'b0);
        snoop_one(3'd4, 1'b0);
        snoop_one(3'd3, 1'b0);

        // R6: write clears resident line, no count, clean snoop
        do_req(2'd1, 16'h0100, 3'd6);
        counters("R6 write leaves counters", 2, 4);
        snoop_run(3'd6, 0);
        do_req(2'd0, 16'h0100, 3'd7);
        counters("R6 read after write misses", 2, 5);
        snoop_run(3'd7, NST);
        do_req(2'd2, 16'h0120, 3'd0);
        snoop_run(3'd0, 0);
        do_req(2'd0, 16'h0120, 3'd1);
        counters("R6 read after invalidate misses", 2, 6);
        snoop_run(3'd1, NST);
        do_req(2'd1, 16'h0340, 3'd2);
        snoop_run(3'd2, 0);
        do_req(2'd0, 16'h0340, 3'd3);
        counters("R6 write does not allocate", 2, 7);
        snoop_run(3'd3, NST);

        // R9: snoop window for an idle slot
        snoop_one(3'd4, 1'b0);

        // R8: hit counter saturates
        for (int k = 0; k < 16; k++) begin
            do_req(2'd0, 16'h0120, 3'd5);
            snoop_run(3'd5, 0);
        end
        counters("R8 saturation", 15, 7);

        repeat (3) @(negedge clk);
        check("R10 all responses seen", 32'(exp_q.size()), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule